// File: doc/BRIEF.md
# SMBus Pointer-Register Slave

This block is a two-wire bus slave (SMBus/I2C signalling) that gives a bus master access to a small internal file of 8-bit registers through an 8-bit pointer register. The bus lines are oversampled by the block clock. START and STOP conditions are recognised from the synchronised lines. The 7-bit device address has a fixed upper part. Its two low bits come from a three-level board strap, which is captured only while reset is held. The block acknowledges frames that carry its address and stays silent on all others.

A write frame always loads the pointer with its first data byte. An optional second byte is stored into the register the pointer selects. A read frame returns one byte from the register the pointer selects. That pointer is normally left by an earlier pointer-only write frame, although a repeated START after the pointer byte also works. A host-side read port lets the rest of the chip observe the register contents at any time.

Top module: `smb_ptr_slave`

## Requirements
- R1: The device address is 7'b01011 followed by two strap bits {A1,A0}. The strap input code maps as follows: 2'b00 (tied low) gives 2'b10, 2'b01 (left open) gives 2'b00, 2'b10 (tied high) gives 2'b01, and 2'b11 is treated as open. The slave acknowledges only a matching address byte, whose bit 0 is the direction (0 write, 1 read).
- R2: The strap code is captured only while rst_n is low. A change of strap_i after reset does not change the address the slave answers to.
- R3: After a non-matching address byte, the slave keeps SDA released until the next START. It acknowledges none of the following bytes, and the pointer and registers stay unchanged.
- R4: The first data byte of every write frame is loaded into the pointer and acknowledged. A frame with only that byte changes no register.
- R5: The second data byte of a write frame is stored into the register at the pointer and acknowledged, with exactly one write per frame.
- R6: Third and later data bytes of a write frame are not acknowledged and are not stored.
- R7: A read frame shifts out the register at the pointer, MSB first. The slave then releases SDA, so any further byte in the same frame reads as 8'hFF.
- R8: Registers exist at pointer values 0 to NUM_REGS-1 (16 by default). A read at a higher pointer returns 8'h00. A write there is acknowledged but stores nothing.
- R9: The slave changes its SDA drive only while SCL is low, after the SCL falling edge that follows a sampled bit.
- R10: While rst_n is low (synchronous), the pointer becomes 8'h00 and register i takes the default DEF_SEED + i, with DEF_SEED = 8'h40.
- R11: A START seen in the middle of a frame (repeated START) restarts address decoding, and a STOP returns the slave to idle.
- R12: hst_rdata combinationally shows the register at hst_addr, or 8'h00 for an address of NUM_REGS or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset; also the strap capture window |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Data output value, always 0 (open-drain) |
| sda_oe | output | 1 | Data output enable; 1 pulls SDA low |
| strap_i | input | 2 | Three-level strap code: 00 low, 01 open, 10 high |
| hst_addr | input | 8 | Host-side register read address |
| hst_rdata | output | 8 | Host-side register read data |

## Verification
Each bus line passes through two synchronising flops and one edge register. The slave therefore moves sda_oe on the third clock edge after SCL falls at the pad, and a stored byte appears on hst_rdata at that same edge. START and STOP are recognised on the third edge after the SDA change. The bench holds every bus phase for eight clocks. It samples the slave's acknowledge or data bit four clocks into the SCL high phase, and reads hst_rdata only after the STOP. Every input is driven and every output sampled on the falling clock edge, well clear of those latencies. A bench monitor also confirms that sda_oe never changes while the bench holds SCL high.

// File: rtl/smb_ptr_pkg.sv
// Shared types and constants of the pointer-register bus slave.
// Assumes a 2-bit strap code from a three-level pad receiver.
package smb_ptr_pkg;

    localparam logic [4:0] DEV_ADDR_HI = 5'b01011;

    localparam logic [1:0] STRAP_LOW  = 2'b00;
    localparam logic [1:0] STRAP_OPEN = 2'b01;
    localparam logic [1:0] STRAP_HIGH = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_IGNORE
    } bus_st_e;

    // Map the strap code to the low address pair {A1,A0}
    function automatic logic [1:0] strap_to_lo(input logic [1:0] code);
        logic [1:0] lo;
        case (code)
            STRAP_LOW:  lo = 2'b10;
            STRAP_HIGH: lo = 2'b01;
            default:    lo = 2'b00;
        endcase
        return lo;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Synchronises SCL and SDA into the block clock and flags edges,
// START and STOP. Assumes the bus is much slower than clk.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    // Shift pad levels through the synchroniser; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
    end

    // Keep the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_strap_latch.sv
// Captures the low device-address pair from the strap while reset
// is held, and holds it until the next reset.
module smb_strap_latch
    import smb_ptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_i,
    output logic [1:0] addr_lo
);
    // Follow the strap only during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo <= strap_to_lo(strap_i);
        end
    end

    AST_ADDR_LO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(addr_lo)); // R2

endmodule

// File: rtl/smb_regfile.sv
// Register file with one write port and two combinational read ports.
// Out-of-range reads return zero and out-of-range writes are dropped.
module smb_regfile #(
    parameter int         NUM_REGS = 16,
    parameter logic [7:0] DEF_SEED = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr_a,
    output logic [7:0] rdata_a,
    input  logic [7:0] raddr_b,
    output logic [7:0] rdata_b
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [7:0] mem [NUM_REGS];

    // Load defaults on reset, else store one addressed byte
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                mem[i] <= DEF_SEED + 8'(i);
            end else if (we && (waddr == 8'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    // Range-checked read ports
    always_comb begin
        rdata_a = (32'(raddr_a) < NUM_REGS) ? mem[raddr_a[IDX_W-1:0]] : 8'h00;
        rdata_b = (32'(raddr_b) < NUM_REGS) ? mem[raddr_b[IDX_W-1:0]] : 8'h00;
    end

    AST_REG0_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem[0] == DEF_SEED)); // R10
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we); // R5

endmodule

// File: rtl/smb_slave_fsm.sv
// Bus protocol engine: address match, pointer load, register write
// strobe and read shifting. Acts on synchronised edge pulses and
// launches SDA changes only on SCL falling edges.
module smb_slave_fsm
    import smb_ptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] addr_lo,
    input  logic [7:0] rf_rdata,
    output logic [7:0] ptr,
    output logic       rf_we,
    output logic [7:0] rf_wdata,
    output logic       sda_oe
);
    bus_st_e    state;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic [1:0] byte_idx;
    logic       rw;
    logic       addr_hit;
    logic       byte_done;

    assign addr_hit  = (shreg[7:1] == {DEV_ADDR_HI, addr_lo});
    assign byte_done = scl_fall && (bit_cnt == 4'd8);

    // Main protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            txreg    <= '0;
            byte_idx <= '0;
            rw       <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        if (addr_hit) begin
                            state  <= ST_ADDR_ACK;
                            sda_oe <= 1'b1;
                            rw     <= shreg[0];
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            state   <= ST_RD;
                            sda_oe  <= ~rf_rdata[7];
                            txreg   <= {rf_rdata[6:0], 1'b0};
                            bit_cnt <= 4'd1;
                        end else begin
                            state   <= ST_WR;
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        state <= ST_WR_ACK;
                        if (byte_idx == 2'd0) begin
                            ptr <= shreg;
                        end
                        if (byte_idx != 2'd2) begin
                            sda_oe   <= 1'b1;
                            byte_idx <= byte_idx + 2'd1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state   <= ST_WR;
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                    end
                end
                ST_RD: begin
                    if (byte_done) begin
                        state  <= ST_IGNORE;
                        sda_oe <= 1'b0;
                    end else if (scl_fall) begin
                        sda_oe  <= ~txreg[7];
                        txreg   <= {txreg[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // Write strobe for the second data byte of a write frame
    always_comb begin
        rf_we    = (state == ST_WR) && byte_done && (byte_idx == 2'd1)
                   && !start_det && !stop_det;
        rf_wdata = shreg;
    end

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R9
    AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (!scl_s || $past(start_det || stop_det))); // R9
    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe); // R3
    AST_PTR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ptr == 8'h00)); // R10
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && !sda_oe)); // R11

endmodule

// File: rtl/smb_ptr_slave.sv
// Top of the pointer-register bus slave: line synchroniser, strap
// capture, protocol engine and register file. SDA is open-drain.
module smb_ptr_slave #(
    parameter int         NUM_REGS    = 16,
    parameter logic [7:0] DEF_SEED    = 8'h40,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe,
    input  logic [1:0] strap_i,
    input  logic [7:0] hst_addr,
    output logic [7:0] hst_rdata
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [1:0] addr_lo;
    logic [7:0] ptr, ptr_rdata, rf_wdata;
    logic       rf_we;

    assign sda_o = 1'b0;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    smb_strap_latch u_strap (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .addr_lo(addr_lo)
    );

    smb_slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .addr_lo(addr_lo), .rf_rdata(ptr_rdata),
        .ptr(ptr), .rf_we(rf_we), .rf_wdata(rf_wdata), .sda_oe(sda_oe)
    );

    smb_regfile #(.NUM_REGS(NUM_REGS), .DEF_SEED(DEF_SEED)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(ptr),
        .wdata(rf_wdata), .raddr_a(ptr), .rdata_a(ptr_rdata),
        .raddr_b(hst_addr), .rdata_b(hst_rdata)
    );

endmodule

// File: tb/smb_ptr_slave_tb.sv
// Self-checking bench: acts as bus master with eight-clock phases.
module smb_ptr_slave_tb;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam int         NREGS      = 16;
    localparam logic [7:0] SEED       = 8'h40;
    localparam logic [6:0] A_OPEN     = 7'h2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic [7:0] hst_addr = 8'h00;
    logic       sda_oe, sda_o, sda_line, oe_prev;
    logic [7:0] hst_rdata;
    int         checks = 0;
    int         fails = 0;
    int         r9_viol = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_ptr_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(strap),
        .hst_addr(hst_addr), .hst_rdata(hst_rdata)
    );

    // R9 monitor: slave drive must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl) r9_viol++;
        oe_prev = sda_oe;
    end

    function automatic logic [7:0] wval(input int p);
        return 8'hC3 ^ 8'(p * 17);
    endfunction

    function automatic logic [7:0] defv(input int p);
        return (p < NREGS) ? SEED + 8'(p) : 8'h00;
    endfunction

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] code);
        strap = code;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        sda_m = 1'b0; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl = 1'b1;   wait_q();
            scl = 1'b0;   wait_q();
        end
        sda_m = 1'b1; wait_q();
        scl = 1'b1;
        repeat (Q/2) @(negedge clk);
        ack = ~sda_line;
        repeat (Q/2) @(negedge clk);
        scl = 1'b0; wait_q();
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wait_q();
            scl = 1'b1;
            repeat (Q/2) @(negedge clk);
            d[i] = sda_line;
            repeat (Q/2) @(negedge clk);
            scl = 1'b0; wait_q();
        end
        sda_m = nack; wait_q();
        scl = 1'b1;   wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic ptr_set(input logic [6:0] a, input logic [7:0] p,
                           output logic aa, output logic pa);
        bus_start();
        send_byte({a, 1'b0}, aa);
        send_byte(p, pa);
        bus_stop();
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                             output logic aa, output logic pa, output logic da);
        bus_start();
        send_byte({a, 1'b0}, aa);
        send_byte(p, pa);
        send_byte(d, da);
        bus_stop();
    endtask

    task automatic reg_read(input logic [6:0] a, output logic aa, output logic [7:0] d);
        bus_start();
        send_byte({a, 1'b1}, aa);
        recv_byte(d, 1'b1);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic       aa, pa, da;
        logic [7:0] d, d2;
        oe_prev = 1'b0;

        // R10 / R12: reset defaults over the host port, including out of range
        do_reset(2'b01);
        chk("R10 sda released in reset state", {7'd0, sda_oe}, 8'h00);
        for (int p = 0; p < NREGS + 2; p++) begin
            hst_addr = 8'(p);
            @(negedge clk);
            chk($sformatf("R12 host read reg %0d", p), hst_rdata, defv(p));
        end
        reg_read(A_OPEN, aa, d);
        chk("R10 pointer 00h after reset", d, SEED);

        // R1 / R3: strap code sweep against every low address pair
        for (int c = 0; c < 3; c++) begin
            logic [1:0] exp_lo;
            exp_lo = (c == 0) ? 2'b10 : ((c == 1) ? 2'b00 : 2'b01);
            do_reset(2'(c));
            for (int lo = 0; lo < 4; lo++) begin
                ptr_set({5'b01011, 2'(lo)}, 8'h05, aa, pa);
                chk($sformatf("R1 strap %0d lo %0d ack", c, lo), {7'd0, aa},
                    {7'd0, (2'(lo) == exp_lo)});
            end
            ptr_set({5'b01010, exp_lo}, 8'h05, aa, pa);
            chk("R3 wrong upper address nack", {7'd0, aa}, 8'h00);
        end

        // R2: strap change after reset is ignored
        do_reset(2'b00);
        strap = 2'b10;
        ptr_set(7'h2E, 8'h00, aa, pa);
        chk("R2 latched address still acked", {7'd0, aa}, 8'h01);
        ptr_set(7'h2D, 8'h00, aa, pa);
        chk("R2 new strap address nacked", {7'd0, aa}, 8'h00);

        // R4 / R5 / R7 / R8: write, pointer-only set, then read every pointer
        do_reset(2'b01);
        for (int p = 0; p < NREGS + 2; p++) begin
            reg_write(A_OPEN, 8'(p), wval(p), aa, pa, da);
            chk($sformatf("R5 acks on write %0d", p), {5'd0, aa, pa, da}, 8'h07);
            hst_addr = 8'(p);
            @(negedge clk);
            chk($sformatf("R5 R8 host value %0d", p), hst_rdata,
                (p < NREGS) ? wval(p) : 8'h00);
            ptr_set(A_OPEN, 8'(p), aa, pa);
            chk($sformatf("R4 pointer-only ack %0d", p), {6'd0, aa, pa}, 8'h03);
            reg_read(A_OPEN, aa, d);
            chk($sformatf("R7 R8 read back %0d", p), d,
                (p < NREGS) ? wval(p) : 8'h00);
        end
        hst_addr = 8'd5;
        @(negedge clk);
        chk("R4 pointer-only frames kept reg 5", hst_rdata, wval(5));

        // R6: third data byte is refused and not stored
        bus_start();
        send_byte({A_OPEN, 1'b0}, aa);
        send_byte(8'h03, pa);
        send_byte(8'h5A, da);
        send_byte(8'h77, aa);
        bus_stop();
        chk("R6 third byte nacked", {7'd0, aa}, 8'h00);
        hst_addr = 8'd3; @(negedge clk);
        chk("R6 reg 3 holds second byte", hst_rdata, 8'h5A);
        hst_addr = 8'd4; @(negedge clk);
        chk("R6 reg 4 untouched", hst_rdata, wval(4));

        // R7: one byte per read frame, the next reads FFh
        bus_start();
        send_byte({A_OPEN, 1'b1}, aa);
        recv_byte(d, 1'b0);
        recv_byte(d2, 1'b1);
        bus_stop();
        chk("R7 first read byte", d, 8'h5A);
        chk("R7 second read byte released", d2, 8'hFF);

        // R3: foreign frame is not acked and changes nothing
        bus_start();
        send_byte({7'h2D, 1'b0}, aa);
        send_byte(8'h07, pa);
        send_byte(8'h99, da);
        bus_stop();
        chk("R3 foreign frame acks", {5'd0, aa, pa, da}, 8'h00);
        hst_addr = 8'd7; @(negedge clk);
        chk("R3 reg 7 unchanged", hst_rdata, wval(7));
        reg_read(A_OPEN, aa, d);
        chk("R3 pointer unchanged", d, 8'h5A);

        // R11: pointer byte, repeated START, read
        bus_start();
        send_byte({A_OPEN, 1'b0}, aa);
        send_byte(8'h09, pa);
        bus_start();
        send_byte({A_OPEN, 1'b1}, da);
        recv_byte(d, 1'b1);
        bus_stop();
        chk("R11 repeated start acks", {5'd0, aa, pa, da}, 8'h07);
        chk("R11 repeated start read", d, wval(9));

        // R9: drive changes only while SCL low
        chk("R9 drive changes while SCL high", 8'(r9_viol), 8'h00);

        // R10: reset after writes restores defaults and pointer
        do_reset(2'b01);
        hst_addr = 8'd3; @(negedge clk);
        chk("R10 reg 3 default again", hst_rdata, SEED + 8'd3);
        reg_read(A_OPEN, aa, d);
        chk("R10 pointer reset to 00h", d, SEED);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule